// File: doc/BRIEF.md
# Shared-SRAM Multi-Queue Buffer Controller

This block divides a single SRAM of 64-bit words into several independent circular queues. Every queue owns a region of the SRAM given by a programmable base word and a depth, plus a small counting state (fill level, write pointer and read pointer). A producer port appends one entry to a chosen queue and a consumer port removes the oldest entry of a chosen queue. The controller turns the queue number and the current pointer into an SRAM word address (base plus pointer), checks that the queue can take the operation, and updates the counting state.

Software programs the queues through a small 32-bit register bus. A queue must be stopped before its base or depth may change. A clear request empties a queue over several cycles. A busy bitmap shows which queues are still clearing. The SRAM has one port, and the producer has priority over the consumer when both ask in the same cycle.

Top module: `qbuf_hub`

## Requirements
- R1: After synchronous reset every queue is stopped, with base 0, depth 0 and level 0. The busy and run bitmaps read 0, and no acknowledge or error output is high.
- R2: Register reads return data on `reg_rdata` in the cycle after `reg_rd`, with `reg_rvalid` high in that cycle. The address byte splits into a page (bits 7:4) and an offset (bits 3:0). Page 0 holds offset 0x0, the busy bitmap (bit q for queue q), and offset 0x4, the run bitmap. Page q+1 belongs to queue q. In that page, offset 0x0 is run (bit 0) and offset 0x4 is the base word. Offset 0x8 is the depth in entries. At offset 0xC a write with bit 0 set starts a clear, and a read returns the fill level.
- R3: Writes to a queue's base or depth are ignored while its run bit is 1 and take effect while it is 0.
- R4: A producer request that is granted to a running, idle, non-full queue writes `prod_data` at SRAM word base+write pointer. It answers with a one-cycle `prod_ack` in the cycle after the grant, and the level rises by one.
- R5: A consumer request that is granted to a running, idle, non-empty queue answers with `cons_ack` in the cycle after the grant. `cons_data` holds the oldest entry in that cycle, so entries leave in FIFO order. Pointers wrap to 0 when they reach the depth, including depths that are not powers of two.
- R6: A push to a full queue or a pop from an empty queue is refused with a one-cycle error pulse, and the queue contents are unchanged.
- R7: Any access to a stopped queue is refused with a one-cycle error pulse, and no state changes.
- R8: A clear written while the queue is not busy sets its busy bit for exactly CLR_CYCLES cycles, starting in the cycle after the write. Accesses to that queue are refused during this time. When busy falls, the level is 0 and all earlier entries are discarded.
- R9: When producer and consumer are both granted-eligible in the same cycle, the producer is served first and the consumer in the next cycle. At most one of the four response outputs is high in any cycle.
- R10: Queues that share the SRAM through different bases hold their entries independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address (page, offset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid |
| prod_req | input | 1 | Producer request, held until a response |
| prod_qid | input | QW | Producer queue number |
| prod_data | input | 64 | Entry to append |
| prod_ack | output | 1 | Producer entry accepted |
| prod_err | output | 1 | Producer request refused |
| cons_req | input | 1 | Consumer request, held until a response |
| cons_qid | input | QW | Consumer queue number |
| cons_ack | output | 1 | Consumer entry delivered |
| cons_err | output | 1 | Consumer request refused |
| cons_data | output | 64 | Entry removed from the queue |

## Verification
The bench checks the wrap point of a depth-5 queue and a depth-1 queue. A design that wraps on a power-of-two boundary would return stale or overwritten entries there. It checks the busy bit cycle by cycle after a clear, because an off-by-one timer would show up as a busy window that is one cycle too long or too short. It also checks that entries pushed before the clear are gone afterwards. It issues simultaneous producer and consumer requests on an empty queue: the consumer must receive the entry the producer has just written, and a wrong priority would answer with an empty-queue error. Writes to base and depth on a running queue must not change the values read back. Random push, pop and run-bit traffic across queues with adjacent bases would expose an address that ignores the base.

// File: rtl/qbuf_pkg.sv
package qbuf_pkg;
  // Offsets inside page 0 (global page)
  localparam logic [3:0] GL_BUSY   = 4'h0;
  localparam logic [3:0] GL_RUN    = 4'h4;
  // Offsets inside a queue page
  localparam logic [3:0] OFS_START = 4'h0;
  localparam logic [3:0] OFS_BASE  = 4'h4;
  localparam logic [3:0] OFS_DEPTH = 4'h8;
  localparam logic [3:0] OFS_CLR   = 4'hC;
  // Arbiter slots, lower index wins
  localparam int SLOT_PROD = 0;
  localparam int SLOT_CONS = 1;
endpackage

// File: rtl/qbuf_sram.sv
module qbuf_sram #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/qbuf_arb.sv
module qbuf_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // Fixed priority: the lowest index that requests is granted.
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end
endmodule

// File: rtl/qbuf_qstate.sv
module qbuf_qstate #(
  parameter int AW         = 8,
  parameter int CLR_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_go,
  input  logic [AW:0]   depth,
  input  logic          inc,
  input  logic          dec,
  output logic [AW:0]   level,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          busy
);
  localparam int LW = AW + 1;
  localparam int TW = $clog2(CLR_CYCLES + 1);

  logic [TW-1:0] tmr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [LW-1:0] d);
    if (({1'b0, p} + LW'(1)) >= d) return '0;
    return p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      wptr  <= '0;
      rptr  <= '0;
      busy  <= 1'b0;
      tmr   <= '0;
    end else if (clr_go) begin
      busy <= 1'b1;
      tmr  <= TW'(CLR_CYCLES - 1);
    end else if (busy) begin
      if (tmr == '0) begin
        busy  <= 1'b0;
        level <= '0;
        wptr  <= '0;
        rptr  <= '0;
      end else begin
        tmr <= tmr - TW'(1);
      end
    end else begin
      if (inc) wptr <= step(wptr, depth);
      if (dec) rptr <= step(rptr, depth);
      level <= level + LW'(inc) - LW'(dec);
    end
  end
endmodule

// File: rtl/qbuf_hub.sv
module qbuf_hub
  import qbuf_pkg::*;
#(
  parameter int NQ         = 4,
  parameter int AW         = 8,
  parameter int CLR_CYCLES = 4,
  localparam int QW        = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid,
  input  logic          prod_req,
  input  logic [QW-1:0] prod_qid,
  input  logic [63:0]   prod_data,
  output logic          prod_ack,
  output logic          prod_err,
  input  logic          cons_req,
  input  logic [QW-1:0] cons_qid,
  output logic          cons_ack,
  output logic          cons_err,
  output logic [63:0]   cons_data
);
  localparam int LW = AW + 1;
  localparam int DW = 64;

  logic [NQ-1:0]         run_r, busy_v, clr_go, inc_v, dec_v;
  logic [NQ-1:0][AW-1:0] base_r, wptr_v, rptr_v;
  logic [NQ-1:0][LW-1:0] depth_r, lvl_v;
  logic [3:0]            page, ofs;
  logic [31:0]           rd_mux;

  assign page = reg_addr[7:4];
  assign ofs  = reg_addr[3:0];

  // Configuration registers; base and depth frozen while running
  always_ff @(posedge clk) begin
    if (rst) begin
      run_r   <= '0;
      base_r  <= '0;
      depth_r <= '0;
    end else if (reg_wr) begin
      for (int q = 0; q < NQ; q++) begin
        if (page == 4'(q + 1)) begin
          case (ofs)
            OFS_START: run_r[q] <= reg_wdata[0];
            OFS_BASE:  if (!run_r[q]) base_r[q] <= reg_wdata[AW-1:0];
            OFS_DEPTH: if (!run_r[q]) depth_r[q] <= reg_wdata[LW-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      clr_go[q] = reg_wr && (page == 4'(q + 1)) && (ofs == OFS_CLR) &&
                  reg_wdata[0] && !busy_v[q];
    end
  end

  // Read path
  always_comb begin
    rd_mux = '0;
    if (page == 4'd0) begin
      case (ofs)
        GL_BUSY: rd_mux = 32'(busy_v);
        GL_RUN:  rd_mux = 32'(run_r);
        default: rd_mux = '0;
      endcase
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (page == 4'(q + 1)) begin
          case (ofs)
            OFS_START: rd_mux = 32'(run_r[q]);
            OFS_BASE:  rd_mux = 32'(base_r[q]);
            OFS_DEPTH: rd_mux = 32'(depth_r[q]);
            OFS_CLR:   rd_mux = 32'(lvl_v[q]);
            default:   rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  // Per-queue counting state
  for (genvar q = 0; q < NQ; q++) begin : g_q
    qbuf_qstate #(.AW(AW), .CLR_CYCLES(CLR_CYCLES)) u_st (
      .clk    (clk),
      .rst    (rst),
      .clr_go (clr_go[q]),
      .depth  (depth_r[q]),
      .inc    (inc_v[q]),
      .dec    (dec_v[q]),
      .level  (lvl_v[q]),
      .wptr   (wptr_v[q]),
      .rptr   (rptr_v[q]),
      .busy   (busy_v[q])
    );
  end

  // Request qualification
  function automatic logic id_in_range(input logic [QW-1:0] id);
    return {1'b0, id} < (QW + 1)'(NQ);
  endfunction

  logic p_ok, c_ok, mem_we, mem_re;
  logic [1:0] arb_req, arb_gnt;
  logic [AW-1:0] mem_addr;

  assign p_ok = id_in_range(prod_qid) && run_r[prod_qid] && !busy_v[prod_qid] &&
                (lvl_v[prod_qid] < depth_r[prod_qid]);
  assign c_ok = id_in_range(cons_qid) && run_r[cons_qid] && !busy_v[cons_qid] &&
                (lvl_v[cons_qid] != '0);

  // A port in its response cycle is not considered again
  assign arb_req[SLOT_PROD] = prod_req && !prod_ack && !prod_err;
  assign arb_req[SLOT_CONS] = cons_req && !cons_ack && !cons_err;

  qbuf_arb #(.N(2)) u_arb (
    .req (arb_req),
    .gnt (arb_gnt)
  );

  assign mem_we   = arb_gnt[SLOT_PROD] && p_ok;
  assign mem_re   = arb_gnt[SLOT_CONS] && c_ok;
  assign mem_addr = arb_gnt[SLOT_PROD] ? (base_r[prod_qid] + wptr_v[prod_qid])
                                       : (base_r[cons_qid] + rptr_v[cons_qid]);

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      inc_v[q] = mem_we && (prod_qid == QW'(q));
      dec_v[q] = mem_re && (cons_qid == QW'(q));
    end
  end

  qbuf_sram #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (mem_addr),
    .wdata (prod_data),
    .rdata (cons_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_ack <= 1'b0;
      prod_err <= 1'b0;
      cons_ack <= 1'b0;
      cons_err <= 1'b0;
    end else begin
      prod_ack <= arb_gnt[SLOT_PROD] && p_ok;
      prod_err <= arb_gnt[SLOT_PROD] && !p_ok;
      cons_ack <= arb_gnt[SLOT_CONS] && c_ok;
      cons_err <= arb_gnt[SLOT_CONS] && !c_ok;
    end
  end
endmodule

// File: rtl/qbuf_hub_chk.sv
module qbuf_hub_chk #(
  parameter int NQ = 4,
  parameter int AW = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   reg_rd,
  input logic                   reg_rvalid,
  input logic                   prod_req,
  input logic                   prod_ack,
  input logic                   prod_err,
  input logic                   cons_req,
  input logic                   cons_ack,
  input logic                   cons_err,
  input logic [NQ-1:0]          clr_go,
  input logic [NQ-1:0]          busy,
  input logic [NQ-1:0][AW:0]    lvl
);
  // R2
  rd_valid_next_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  // R9
  single_resp_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prod_ack, prod_err, cons_ack, cons_err}));

  // R4
  prod_resp_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    (prod_ack || prod_err) |-> $past(prod_req));

  // R5
  cons_resp_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    (cons_ack || cons_err) |-> $past(cons_req));

  for (genvar q = 0; q < NQ; q++) begin : g_c
    // R8
    clr_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
      clr_go[q] |=> busy[q]);
    // R8
    clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy[q]) |-> (lvl[q] == '0));
  end
endmodule

bind qbuf_hub qbuf_hub_chk #(.NQ(NQ), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_rd     (reg_rd),
  .reg_rvalid (reg_rvalid),
  .prod_req   (prod_req),
  .prod_ack   (prod_ack),
  .prod_err   (prod_err),
  .cons_req   (cons_req),
  .cons_ack   (cons_ack),
  .cons_err   (cons_err),
  .clr_go     (clr_go),
  .busy       (busy_v),
  .lvl        (lvl_v)
);

// File: tb/qbuf_hub_tb_top.sv
`timescale 1ns/1ps
module qbuf_hub_tb_top;
  localparam int NQ  = 4;
  localparam int AW  = 8;
  localparam int CLR = 4;
  localparam int QW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;
  logic prod_req = 0, cons_req = 0;
  logic [QW-1:0] prod_qid = '0, cons_qid = '0;
  logic [63:0] prod_data = '0;
  logic prod_ack, prod_err, cons_ack, cons_err;
  logic [63:0] cons_data;

  int checks = 0;
  int errors = 0;

  logic [63:0] mq [NQ][$];
  int  mdep [NQ];
  bit  men  [NQ];

  always #2.5 clk = ~clk;

  qbuf_hub #(.NQ(NQ), .AW(AW), .CLR_CYCLES(CLR)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .prod_req(prod_req), .prod_qid(prod_qid), .prod_data(prod_data),
    .prod_ack(prod_ack), .prod_err(prod_err), .cons_req(cons_req),
    .cons_qid(cons_qid), .cons_ack(cons_ack), .cons_err(cons_err),
    .cons_data(cons_data)
  );

  function automatic logic [7:0] qa(input int q, input int ofs);
    return 8'((q + 1) * 16 + ofs);
  endfunction

  function automatic bit exp_push_ok(input int q);
    return men[q] && (mq[q].size() < mdep[q]);
  endfunction

  function automatic bit exp_pop_ok(input int q);
    return men[q] && (mq[q].size() > 0);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
    chk("R2 rvalid", 64'(reg_rvalid), 64'd1);
  endtask

  task automatic do_push(input int q, input logic [63:0] d, output bit ack, output bit err);
    @(negedge clk);
    prod_req = 1; prod_qid = QW'(q); prod_data = d;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (prod_ack || prod_err) break;
    end
    ack = prod_ack; err = prod_err;
    prod_req = 0;
  endtask

  task automatic do_pop(input int q, output bit ack, output bit err, output logic [63:0] d);
    @(negedge clk);
    cons_req = 1; cons_qid = QW'(q);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cons_ack || cons_err) break;
    end
    ack = cons_ack; err = cons_err; d = cons_data;
    cons_req = 0;
  endtask

  task automatic push_chk(input string req, input int q, input logic [63:0] d);
    bit ack, err, ok;
    ok = exp_push_ok(q);
    do_push(q, d, ack, err);
    chk({req, " push ack"}, 64'(ack), 64'(ok));
    chk({req, " push err"}, 64'(err), 64'(!ok));
    if (ok) mq[q].push_back(d);
  endtask

  task automatic pop_chk(input string req, input int q);
    bit ack, err, ok;
    logic [63:0] d, e;
    ok = exp_pop_ok(q);
    do_pop(q, ack, err, d);
    chk({req, " pop ack"}, 64'(ack), 64'(ok));
    chk({req, " pop err"}, 64'(err), 64'(!ok));
    if (ok) begin
      e = mq[q].pop_front();
      chk({req, " pop data"}, d, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] rv;
    logic [63:0] dd;
    bit a1, e1;
    void'($urandom(32'h5eed));
    for (int q = 0; q < NQ; q++) begin mdep[q] = 0; men[q] = 0; end

    repeat (5) @(negedge clk);
    rst = 0;

    // R1: reset state
    chk("R1 prod_ack", 64'(prod_ack), 0);
    chk("R1 cons_err", 64'(cons_err), 0);
    reg_read(8'h00, rv); chk("R1 busy map", 64'(rv), 0);
    reg_read(8'h04, rv); chk("R1 run map", 64'(rv), 0);
    reg_read(qa(0, 8), rv); chk("R1 depth", 64'(rv), 0);
    reg_read(qa(3, 12), rv); chk("R1 level", 64'(rv), 0);

    // R7: stopped queue refuses both ports
    push_chk("R7", 0, 64'h1111);
    pop_chk("R7", 0);
    reg_read(qa(0, 12), rv); chk("R7 level unchanged", 64'(rv), 0);

    // Configure: bases 0,16,32,48; depths 4,5,16,1
    mdep[0] = 4; mdep[1] = 5; mdep[2] = 16; mdep[3] = 1;
    for (int q = 0; q < NQ; q++) begin
      reg_write(qa(q, 4), 32'(q * 16));
      reg_write(qa(q, 8), 32'(mdep[q]));
      reg_write(qa(q, 0), 32'd1);
      men[q] = 1;
    end
    reg_read(8'h04, rv); chk("R2 run map", 64'(rv), 64'hF);

    // R3: base/depth frozen while running
    reg_write(qa(1, 4), 32'd99);
    reg_read(qa(1, 4), rv); chk("R3 base frozen", 64'(rv), 16);
    reg_write(qa(1, 8), 32'd9);
    reg_read(qa(1, 8), rv); chk("R3 depth frozen", 64'(rv), 5);
    reg_write(qa(1, 0), 32'd0);
    reg_write(qa(1, 4), 32'd20);
    reg_read(qa(1, 4), rv); chk("R3 base when stopped", 64'(rv), 20);
    reg_write(qa(1, 4), 32'd16);
    reg_write(qa(1, 0), 32'd1);

    // R4, R5, R6: fill depth-5 queue past full, drain past empty
    for (int i = 0; i < 7; i++) push_chk("R4 R6", 1, 64'hA000 + 64'(i));
    reg_read(qa(1, 12), rv); chk("R4 level full", 64'(rv), 5);
    for (int i = 0; i < 6; i++) pop_chk("R5 R6", 1);
    // R5: wrap on non-power-of-two and depth-1 queues
    for (int i = 0; i < 12; i++) begin
      push_chk("R5 wrap", 1, 64'hB000 + 64'(i));
      push_chk("R5 wrap", 1, 64'hC000 + 64'(i));
      pop_chk("R5 wrap", 1);
      push_chk("R5 depth1", 3, 64'hD000 + 64'(i));
      push_chk("R6 depth1 full", 3, 64'hE000 + 64'(i));
      pop_chk("R5 depth1", 3);
    end

    // R9: simultaneous requests on empty queue 2
    @(negedge clk);
    prod_req = 1; prod_qid = 2'd2; prod_data = 64'hFACE_0001;
    cons_req = 1; cons_qid = 2'd2;
    @(negedge clk);
    chk("R9 producer first", 64'(prod_ack), 1);
    chk("R9 consumer waits", 64'({cons_ack, cons_err}), 0);
    prod_req = 0;
    @(negedge clk);
    chk("R9 consumer next", 64'(cons_ack), 1);
    chk("R9 consumer data", cons_data, 64'hFACE_0001);
    cons_req = 0;

    // R8: clear with entries inside; busy window exact
    for (int i = 0; i < 3; i++) push_chk("R8 pre", 2, 64'h7700 + 64'(i));
    reg_write(qa(2, 12), 32'd1);
    reg_rd = 1; reg_addr = 8'h00;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R8 busy window", 64'(reg_rdata[2]), 64'(k <= CLR));
    end
    reg_rd = 0;
    reg_read(qa(2, 12), rv); chk("R8 level after clear", 64'(rv), 0);
    mq[2].delete();
    pop_chk("R8 discarded", 2);
    // R8: access during busy refused
    reg_write(qa(2, 12), 32'd1);
    do_push(2, 64'h55, a1, e1);
    chk("R8 push during busy", 64'(e1), 1);
    repeat (CLR + 2) @(negedge clk);
    push_chk("R8 after clear", 2, 64'h9999);
    pop_chk("R8 after clear", 2);

    // R10 and R7: random traffic across queues with adjacent bases
    for (int n = 0; n < 400; n++) begin
      int op, q;
      op = int'($urandom_range(0, 99));
      q  = int'($urandom_range(0, NQ - 1));
      if (op < 46) begin
        dd = {$urandom, $urandom};
        push_chk("R10", q, dd);
      end else if (op < 92) begin
        pop_chk("R10", q);
      end else begin
        men[q] = !men[q];
        reg_write(qa(q, 0), 32'(men[q]));
      end
    end
    for (int q = 0; q < NQ; q++) begin
      reg_read(qa(q, 12), rv);
      chk("R10 final level", 64'(rv), 64'(mq[q].size()));
    end

    summary();
  end
endmodule